// File: doc/BRIEF.md
# Mode-Aware Stack Pointer Unit

This block holds the 16-bit stack pointer of a processor core that runs either in a native 16-bit mode or in an 8-bit emulation mode. It sequences pushes and pulls of one or two bytes over a synchronous byte-wide memory port. It also assembles pulled words and keeps the pointer up to date after every byte. A register-transfer path can load the pointer directly in one cycle.

In emulation mode the pointer is held inside page 1 (high byte 0x01). By default the page is re-imposed after every byte step, so the pointer wraps within that page. A per-request option selects the other behaviour. With it set, the steps run across the page boundary freely and page 1 is imposed only once, after the last byte. A busy/done handshake allows one multi-byte operation to be in flight at a time.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads 0x01FF, and busy, done and all memory strobes are low.
- R2: While idle with no request, a load copies all 16 bits of load_val into the pointer on the next edge. In emulation mode the high byte becomes 0x01 instead. A request presented in the same cycle takes precedence over the load.
- R3: A byte push writes req_wdata[7:0] at the current pointer and then decrements the pointer. In native mode the pointer wraps modulo 65536.
- R4: A word push (req_word=1) writes req_wdata[15:8] at the pointer, then req_wdata[7:0] at the pointer minus one, and leaves the pointer two below its start.
- R5: A byte pull (req_pull=1) first increments the pointer and then reads the byte at the new address. rd_data then holds that byte in bits 7:0 with zeros above.
- R6: A word pull reads the low byte at pointer+1 and the high byte at pointer+2. rd_data holds low | high<<8 and the pointer ends two above its start.
- R7: In emulation mode with req_late=0, every byte step forces the pointer high byte to 0x01 before the access. Every address used and the final pointer therefore stay in page 1, and the pointer wraps within that page.
- R8: In emulation mode with req_late=1, steps cross page boundaries freely: pointer and addresses step by a full 16 bits. Only after the last byte is the high byte set to 0x01. In native mode req_late has no effect.
- R9: busy is high from the edge that accepts a request until the final byte completes. done is a one-cycle pulse, with busy low, in the cycle where the final pointer and rd_data are valid. Requests and loads presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| emu_mode | input | 1 | 1 selects 8-bit emulation mode; sampled when a request or load is accepted |
| req_valid | input | 1 | Start a push or pull (accepted only when idle) |
| req_pull | input | 1 | 1 = pull, 0 = push |
| req_word | input | 1 | 1 = two bytes, 0 = one byte |
| req_late | input | 1 | 1 = impose page 1 only once at the end (emulation mode) |
| req_wdata | input | 16 | Data to push; bits 7:0 for a byte push |
| load_en | input | 1 | Direct pointer load from a register transfer |
| load_val | input | 16 | Value for the direct load |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Assembled result of the last pull |
| sp | output | 16 | Current stack pointer |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read strobe |

## Verification
The bench builds the unit with its default 8-bit data width and page value 0x01, so the pointer spans 16 bits. With page 1 as the starting high byte, every low byte from 0x00 to 0xFF is swept. Each start is run through all combinations of push or pull, byte or word, native or emulation, and early or late page fixing. This brings both page-edge wraps within reach, as well as the divergence between the two emulation variants near 0x01FF and 0x0100. Start pages 0x00 and 0xFF at the low-byte extremes cover the native 16-bit wrap. A 64K pattern memory whose contents are a function of the address confirms the byte order and addresses of the pulls.

// File: rtl/spu_pkg.sv
package spu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_PULL = 2'd2,
        ST_FIN  = 2'd3
    } spu_state_e;
endpackage

// File: rtl/spu_pagefix.sv
module spu_pagefix #(
    parameter int W = 16,
    parameter logic [W/2-1:0] PAGE = 1
) (
    input  logic [W-1:0] val,
    input  logic         en,
    output logic [W-1:0] res
);
    localparam int H = W / 2;
    assign res = en ? {PAGE, val[H-1:0]} : val;
endmodule

// File: rtl/spu_stepper.sv
module spu_stepper #(
    parameter int W = 16,
    parameter logic [W/2-1:0] PAGE = 1,
    parameter bit UP = 1'b1
) (
    input  logic [W-1:0] val,
    input  logic         pin,
    output logic [W-1:0] nxt
);
    logic [W-1:0] raw;

    if (UP) begin : g_up
        assign raw = val + W'(1);
    end else begin : g_dn
        assign raw = val - W'(1);
    end

    spu_pagefix #(.W(W), .PAGE(PAGE)) i_fix (
        .val(raw),
        .en (pin),
        .res(nxt)
    );
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
    parameter int DW = 8,
    parameter logic [DW-1:0] EMU_PAGE = 1,
    parameter logic [2*DW-1:0] RESET_SP = {EMU_PAGE, {DW{1'b1}}}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            emu_mode,
    input  logic            req_valid,
    input  logic            req_pull,
    input  logic            req_word,
    input  logic            req_late,
    input  logic [2*DW-1:0] req_wdata,
    input  logic            load_en,
    input  logic [2*DW-1:0] load_val,
    output logic            busy,
    output logic            done,
    output logic [2*DW-1:0] rd_data,
    output logic [2*DW-1:0] sp,
    output logic            mem_en,
    output logic            mem_we,
    output logic [2*DW-1:0] mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata
);
    import spu_pkg::*;

    localparam int SPW = 2 * DW;

    typedef struct packed {
        spu_state_e      st;
        logic [SPW-1:0]  sp;
        logic [1:0]      rem;
        logic            word;
        logic            emu;
        logic            late;
        logic [SPW-1:0]  wbuf;
        logic [SPW-1:0]  rbuf;
        logic            cap;
        logic            cap_hi;
        logic            done;
    } regs_t;

    regs_t r_q, r_d;

    logic           step_pin;
    logic           end_pin;
    logic [SPW-1:0] sp_inc, sp_dec, fin_inc, fin_dec, ld_fixed;

    assign step_pin = r_q.emu && !r_q.late;
    assign end_pin  = r_q.emu && r_q.late;

    spu_stepper #(.W(SPW), .PAGE(EMU_PAGE), .UP(1'b1)) i_inc (
        .val(r_q.sp), .pin(step_pin), .nxt(sp_inc)
    );
    spu_stepper #(.W(SPW), .PAGE(EMU_PAGE), .UP(1'b0)) i_dec (
        .val(r_q.sp), .pin(step_pin), .nxt(sp_dec)
    );
    spu_pagefix #(.W(SPW), .PAGE(EMU_PAGE)) i_fin_inc (
        .val(sp_inc), .en(end_pin), .res(fin_inc)
    );
    spu_pagefix #(.W(SPW), .PAGE(EMU_PAGE)) i_fin_dec (
        .val(sp_dec), .en(end_pin), .res(fin_dec)
    );
    spu_pagefix #(.W(SPW), .PAGE(EMU_PAGE)) i_ld_fix (
        .val(load_val), .en(emu_mode), .res(ld_fixed)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.sp;
        mem_wdata = '0;

        // Capture of the byte read in the previous cycle
        if (r_q.cap) begin
            if (r_q.cap_hi) begin
                r_d.rbuf[SPW-1:DW] = mem_rdata;
            end else begin
                r_d.rbuf = {{DW{1'b0}}, mem_rdata};
            end
        end

        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = req_pull ? ST_PULL : ST_PUSH;
                    r_d.rem  = req_word ? 2'd2 : 2'd1;
                    r_d.word = req_word;
                    r_d.emu  = emu_mode;
                    r_d.late = req_late;
                    r_d.wbuf = req_wdata;
                    r_d.cap  = 1'b0;
                end else if (load_en) begin
                    r_d.sp = ld_fixed;
                end
            end
            ST_PUSH: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.sp;
                mem_wdata = (r_q.rem == 2'd2) ? r_q.wbuf[SPW-1:DW] : r_q.wbuf[DW-1:0];
                r_d.sp    = sp_dec;
                r_d.rem   = r_q.rem - 2'd1;
                if (r_q.rem == 2'd1) begin
                    r_d.sp   = fin_dec;
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            ST_PULL: begin
                mem_en     = 1'b1;
                mem_addr   = sp_inc;
                r_d.sp     = sp_inc;
                r_d.cap    = 1'b1;
                r_d.cap_hi = r_q.word && (r_q.rem == 2'd1);
                r_d.rem    = r_q.rem - 2'd1;
                if (r_q.rem == 2'd1) begin
                    r_d.sp = fin_inc;
                    r_d.st = ST_FIN;
                end
            end
            default: begin
                r_d.cap  = 1'b0;
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
            r_q.sp <= RESET_SP;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign rd_data = r_q.rbuf;
    assign sp      = r_q.sp;

    // R2
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && load_en && !req_valid && !emu_mode |=> sp == $past(load_val));

    // R3
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en && mem_we && !r_q.emu |=> sp == $past(mem_addr) - SPW'(1));

    // R5
    pull_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en && !mem_we && !r_q.emu |=> sp == $past(mem_addr));

    // R7
    emu_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en && !mem_we && r_q.emu && !r_q.late |-> mem_addr[SPW-1:DW] == EMU_PAGE);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !mem_en);
endmodule

// File: tb/test_stack_ptr_unit.sv
module test_stack_ptr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        emu_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_pull = 1'b0;
    logic        req_word = 1'b0;
    logic        req_late = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        load_en = 1'b0;
    logic [15:0] load_val = '0;
    logic        busy, done, mem_en, mem_we;
    logic [15:0] rd_data, sp, mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;

    int          nrd = 0;
    int          nwr = 0;
    logic [15:0] rd_log [4];
    logic [15:0] wa_log [4];
    logic [7:0]  wd_log [4];

    always #5 clk = ~clk;

    stack_ptr_unit i_stack_ptr_unit (
        .clk(clk), .rst_n(rst_n), .emu_mode(emu_mode),
        .req_valid(req_valid), .req_pull(req_pull), .req_word(req_word),
        .req_late(req_late), .req_wdata(req_wdata),
        .load_en(load_en), .load_val(load_val),
        .busy(busy), .done(done), .rd_data(rd_data), .sp(sp),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] patt(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
    endfunction

    function automatic logic [15:0] stp(input logic [15:0] s, input bit up, input bit pin);
        logic [15:0] r;
        r = up ? s + 16'd1 : s - 16'd1;
        return pin ? {8'h01, r[7:0]} : r;
    endfunction

    // Synchronous pattern memory and access log
    always @(posedge clk) begin
        if (mem_en && !mem_we) begin
            mem_rdata       <= patt(mem_addr);
            rd_log[nrd % 4] <= mem_addr;
            nrd             <= nrd + 1;
        end
        if (mem_en && mem_we) begin
            wa_log[nwr % 4] <= mem_addr;
            wd_log[nwr % 4] <= mem_wdata;
            nwr             <= nwr + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [15:0] v, input logic emu);
        @(negedge clk);
        load_en  = 1'b1;
        load_val = v;
        emu_mode = emu;
        @(negedge clk);
        load_en  = 1'b0;
    endtask

    task automatic do_op(input bit pull, input bit word, input bit late,
                         input bit emu, input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        req_pull  = pull;
        req_word  = word;
        req_late  = late;
        req_wdata = wd;
        emu_mode  = emu;
        @(negedge clk);
        req_valid = 1'b0;
        do @(negedge clk); while (!done);
    endtask

    task automatic run_case(input logic [15:0] s0, input bit emu, input bit late,
                            input bit pull, input bit word);
        logic [15:0] wd, a1, a2, s1, fin, exp_rd;
        logic [7:0]  d1, d2;
        int          rb, wb, n;
        string       tag;
        bit          pin;
        pin = emu && !late;
        wd  = {s0[7:0] ^ 8'h3C, ~s0[7:0]};
        n   = word ? 2 : 1;
        if (emu) tag = late ? "R8" : "R7";
        else if (pull) tag = word ? "R6" : "R5";
        else tag = word ? "R4" : "R3";

        do_load(s0, 1'b0);
        rb = nrd;
        wb = nwr;
        do_op(pull, word, late, emu, wd);

        if (!pull) begin
            a1  = s0;
            d1  = word ? wd[15:8] : wd[7:0];
            s1  = stp(s0, 1'b0, pin);
            a2  = s1;
            d2  = wd[7:0];
            fin = word ? stp(s1, 1'b0, pin) : s1;
            if (emu && late) fin[15:8] = 8'h01;
            chk(tag, 32'(nwr - wb), 32'(n));
            chk(tag, 32'(nrd - rb), 32'd0);
            chk(tag, {16'd0, wa_log[wb % 4]}, {16'd0, a1});
            chk(tag, {24'd0, wd_log[wb % 4]}, {24'd0, d1});
            if (word) begin
                chk(tag, {16'd0, wa_log[(wb + 1) % 4]}, {16'd0, a2});
                chk(tag, {24'd0, wd_log[(wb + 1) % 4]}, {24'd0, d2});
            end
        end else begin
            a1  = stp(s0, 1'b1, pin);
            a2  = stp(a1, 1'b1, pin);
            fin = word ? a2 : a1;
            if (emu && late) fin[15:8] = 8'h01;
            exp_rd = word ? {patt(a2), patt(a1)} : {8'h00, patt(a1)};
            chk(tag, 32'(nrd - rb), 32'(n));
            chk(tag, 32'(nwr - wb), 32'd0);
            chk(tag, {16'd0, rd_log[rb % 4]}, {16'd0, a1});
            if (word) chk(tag, {16'd0, rd_log[(rb + 1) % 4]}, {16'd0, a2});
            chk(tag, {16'd0, rd_data}, {16'd0, exp_rd});
        end
        chk(tag, {16'd0, sp}, {16'd0, fin});
        // R9: done pulse with busy low
        chk("R9", {30'd0, busy, done}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int rb, wb;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {16'd0, sp}, 32'h01FF);
        chk("R1", {29'd0, busy, done, mem_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {16'd0, sp}, 32'h01FF);

        // R2 native and emulation loads
        do_load(16'hA5C3, 1'b0);
        chk("R2", {16'd0, sp}, 32'hA5C3);
        do_load(16'hA5C3, 1'b1);
        chk("R2", {16'd0, sp}, 32'h01C3);
        // R2 request wins over simultaneous load
        @(negedge clk);
        emu_mode = 1'b0; req_valid = 1'b1; req_pull = 1'b0; req_word = 1'b0;
        req_late = 1'b0; req_wdata = 16'h0077; load_en = 1'b1; load_val = 16'h4444;
        @(negedge clk);
        req_valid = 1'b0; load_en = 1'b0;
        do @(negedge clk); while (!done);
        chk("R2", {16'd0, sp}, 32'h01C2);

        // R9 requests and loads ignored while busy
        do_load(16'h1234, 1'b0);
        rb = nrd; wb = nwr;
        @(negedge clk);
        req_valid = 1'b1; req_pull = 1'b0; req_word = 1'b1; req_wdata = 16'hBEAD;
        @(negedge clk);
        chk("R9", {31'd0, busy}, 32'd1);
        req_pull = 1'b1; load_en = 1'b1; load_val = 16'hEEEE;
        do @(negedge clk); while (!done);
        req_valid = 1'b0; load_en = 1'b0;
        chk("R9", {16'd0, sp}, 32'h1232);
        chk("R9", 32'(nwr - wb), 32'd2);
        chk("R9", 32'(nrd - rb), 32'd0);
        @(negedge clk);
        @(negedge clk);
        chk("R9", {16'd0, sp}, 32'h1232);

        // Sweep: page 1 with every low byte, pages 0x00/0xFF at the extremes
        for (int h = 0; h < 3; h++) begin
            for (int l = 0; l < 256; l++) begin
                logic [7:0] hb;
                hb = (h == 0) ? 8'h01 : ((h == 1) ? 8'h00 : 8'hFF);
                if (h != 0 && !(l < 2 || l > 253 || l == 128)) continue;
                for (int c = 0; c < 16; c++) begin
                    run_case({hb, 8'(l)}, c[3], c[2], c[1], c[0]);
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule